// File: doc/BRIEF.md
# I2C Controller Control Register

This block holds the 16-bit control word of an I2C controller and enforces the rules for how software and the I2C bit engine may change it. Software writes the whole word through a simple register port (one write strobe, 16 data bits, no byte lanes) and can read it back at any time. The bit engine reports its state on dedicated inputs: bus busy, abort finished, START produced, STOP produced, timeout, the R/W bit captured in a slave address phase, and the three events that take the controller out of master mode.

Each field has its own write rule. Some fields are frozen while the bus is busy. The START and STOP requests exclude each other, clear themselves when the engine reports completion, and are held at zero unless the controller is both enabled and master. In slave mode the direction bit follows the received R/W bit, and during an abort the acknowledge bit is held at NACK. Whenever hardware forces a value and software writes the same field in the same cycle, the hardware value wins. A write that asks for an illegal START/STOP combination is flagged for one cycle on a separate output.

Top module: `i2c_ctrl_reg`

## Requirements
- R1: A synchronous reset clears every register bit and the invalid-request flag to zero.
- R2: The START request (bit 6) and STOP request (bit 7) read zero in every cycle in which enable (bit 0) or master (bit 1) is zero, including when a write tries to set them.
- R3: A write with both bit 6 and bit 7 set clears both requests, and one cycle later the invalid-request output is high for exactly one cycle.
- R4: A write that sets START while STOP is pending, or sets STOP while START is pending, leaves both requests unchanged and raises the invalid-request output one cycle later for one cycle.
- R5: A pending START clears on the cycle after START-produced or timeout is reported, and a pending STOP clears after STOP-produced, even when a write sets it in that same cycle.
- R6: While busy is high, writes to master (bit 1) and direction (bit 2) are ignored, and writes to enable (bit 0) are ignored unless the abort bit (bit 8) is already one.
- R7: While the abort bit is one, the acknowledge bit (bit 5, one means NACK) reads one from the next cycle on and software writes to it are ignored; the abort bit clears when enable is zero or when abort-finished is reported, with priority over a same-cycle write.
- R8: While master is zero, software writes to the direction bit are ignored, and a strobe on the R/W-valid input loads the direction bit from the R/W input.
- R9: An address match, lost arbitration or general call clears the master bit on the next edge, overriding a same-cycle write that sets it.
- R10: The read port always returns the current register word: bit 0 enable, bit 1 master, bit 2 direction (one means receive), bit 4 stretch select, bit 5 acknowledge select, bit 6 START, bit 7 STOP, bit 8 abort; bits 3 and 9 to 15 read zero and ignore writes.
- R11: The stretch-select bit (bit 4, one selects stretching after the 8th falling clock edge, zero after the 9th) takes any written value whether or not the bus is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current register word |
| busy | input | 1 | Engine reports bus transfer in progress |
| start_done | input | 1 | Engine produced the START condition |
| stop_done | input | 1 | Engine produced the STOP condition |
| timeout | input | 1 | Timeout timer expired |
| abort_done | input | 1 | Engine finished the abort |
| rw_valid | input | 1 | Slave address phase captured an R/W bit |
| rw_bit | input | 1 | Captured R/W bit value |
| addr_match | input | 1 | Own slave address matched |
| arb_lost | input | 1 | Arbitration lost |
| gen_call | input | 1 | General call received |
| en_o | output | 1 | Controller enable |
| master_o | output | 1 | Master mode |
| rx_mode_o | output | 1 | Direction, one means receive |
| stretch8_o | output | 1 | Stretch after the 8th edge when one, the 9th when zero |
| nack_o | output | 1 | Acknowledge select, one means NACK |
| start_req_o | output | 1 | START request to the engine |
| stop_req_o | output | 1 | STOP request to the engine |
| bad_req_o | output | 1 | One-cycle flag for an illegal START/STOP write |

## Verification
The assertions assume that engine status pulses are synchronous to the clock and that START-produced and STOP-produced only arrive while the matching request is pending; they make no assumption about write timing, so writes may land in the same cycle as any hardware event. The stimulus drives every input between clock edges, holds each engine pulse for a single cycle, and deliberately places writes on the same cycle as master-clearing events, completion reports, abort completion and R/W capture so that each priority rule is exercised at its collision point.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;

    localparam int WORD_W  = 16;
    localparam int B_EN    = 0;
    localparam int B_MST   = 1;
    localparam int B_MODE  = 2;
    localparam int B_STR   = 4;
    localparam int B_ACK   = 5;
    localparam int B_STA   = 6;
    localparam int B_STO   = 7;
    localparam int B_ABT   = 8;

    typedef struct packed {
        logic abort;
        logic ack;
        logic stretch;
        logic mode;
        logic mst;
        logic en;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
    } req_t;

    typedef struct packed {
        logic busy;
        logic abort_done;
        logic rw_valid;
        logic rw_bit;
        logic addr_match;
        logic arb_lost;
        logic gen_call;
    } eng_t;

    function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.en      = w[B_EN];
        c.mst     = w[B_MST];
        c.mode    = w[B_MODE];
        c.stretch = w[B_STR];
        c.ack     = w[B_ACK];
        c.abort   = w[B_ABT];
        return c;
    endfunction

    function automatic req_t word_to_req(input logic [WORD_W-1:0] w);
        req_t r;
        r.start = w[B_STA];
        r.stop  = w[B_STO];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input cfg_t c, input req_t r);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_EN]   = c.en;
        w[B_MST]  = c.mst;
        w[B_MODE] = c.mode;
        w[B_STR]  = c.stretch;
        w[B_ACK]  = c.ack;
        w[B_STA]  = r.start;
        w[B_STO]  = r.stop;
        w[B_ABT]  = c.abort;
        return w;
    endfunction

endpackage

// File: rtl/i2c_cfg_next.sv
module i2c_cfg_next
    import i2c_ctrl_pkg::*;
(
    input  cfg_t cur,
    input  logic wr_vld,
    input  cfg_t wr,
    input  eng_t eng,
    output cfg_t nxt
);
    logic hw_mst_clr;
    logic en_open;
    logic locked_open;

    assign hw_mst_clr  = eng.addr_match | eng.arb_lost | eng.gen_call;
    assign en_open     = wr_vld & (~eng.busy | cur.abort);
    assign locked_open = wr_vld & ~eng.busy;

    always_comb begin
        nxt = cur;

        // enable: frozen while busy unless an abort is running
        if (en_open) nxt.en = wr.en;

        // master: hardware clear beats the write
        if (locked_open) nxt.mst = wr.mst;
        if (hw_mst_clr)  nxt.mst = 1'b0;

        // direction: software owns it only in master mode
        if (cur.mst) begin
            if (locked_open) nxt.mode = wr.mode;
        end else if (eng.rw_valid) begin
            nxt.mode = eng.rw_bit;
        end

        // stretch select: always writable
        if (wr_vld) nxt.stretch = wr.stretch;

        // acknowledge: held at NACK during abort
        if (cur.abort)   nxt.ack = 1'b1;
        else if (wr_vld) nxt.ack = wr.ack;

        // abort status: cleared by completion or by a disabled controller
        if (wr_vld)                     nxt.abort = wr.abort;
        if (eng.abort_done || !nxt.en)  nxt.abort = 1'b0;
    end

endmodule

// File: rtl/i2c_req_next.sv
module i2c_req_next
    import i2c_ctrl_pkg::*;
(
    input  req_t cur,
    input  logic wr_vld,
    input  req_t wr,
    input  logic start_done,
    input  logic stop_done,
    input  logic timeout,
    input  logic en_nxt,
    input  logic mst_nxt,
    output req_t nxt,
    output logic bad
);
    logic both_set;
    logic start_on_stop;
    logic stop_on_start;

    assign both_set      = wr_vld & wr.start & wr.stop;
    assign start_on_stop = wr_vld & wr.start & ~wr.stop & cur.stop;
    assign stop_on_start = wr_vld & wr.stop & ~wr.start & cur.start;
    assign bad           = both_set | start_on_stop | stop_on_start;

    always_comb begin
        nxt = cur;
        if (both_set)         nxt = '0;
        else if (wr_vld && !bad) nxt = wr;

        if (start_done || timeout) nxt.start = 1'b0;
        if (stop_done)             nxt.stop  = 1'b0;
        if (!en_nxt || !mst_nxt)   nxt       = '0;
    end

endmodule

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
    import i2c_ctrl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              start_done,
    input  logic              stop_done,
    input  logic              timeout,
    input  logic              abort_done,
    input  logic              rw_valid,
    input  logic              rw_bit,
    input  logic              addr_match,
    input  logic              arb_lost,
    input  logic              gen_call,
    output logic              en_o,
    output logic              master_o,
    output logic              rx_mode_o,
    output logic              stretch8_o,
    output logic              nack_o,
    output logic              start_req_o,
    output logic              stop_req_o,
    output logic              bad_req_o
);
    localparam int USE_W = (DATA_W < WORD_W) ? DATA_W : WORD_W;

    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] cur_word;
    cfg_t cfg_q, cfg_d, cfg_wr;
    req_t req_q, req_d, req_wr;
    eng_t eng;
    logic bad_d, bad_q;
    logic unused_bits;

    always_comb begin
        wr_word = '0;
        wr_word[USE_W-1:0] = wr_data[USE_W-1:0];
    end

    assign unused_bits = ^{wr_word[WORD_W-1:B_ABT+1], wr_word[3]};

    assign cfg_wr = word_to_cfg(wr_word);
    assign req_wr = word_to_req(wr_word);

    assign eng = '{busy: busy, abort_done: abort_done, rw_valid: rw_valid,
                   rw_bit: rw_bit, addr_match: addr_match, arb_lost: arb_lost,
                   gen_call: gen_call};

    i2c_cfg_next u_cfg (
        .cur    (cfg_q),
        .wr_vld (wr_en),
        .wr     (cfg_wr),
        .eng    (eng),
        .nxt    (cfg_d)
    );

    i2c_req_next u_req (
        .cur        (req_q),
        .wr_vld     (wr_en),
        .wr         (req_wr),
        .start_done (start_done),
        .stop_done  (stop_done),
        .timeout    (timeout),
        .en_nxt     (cfg_d.en),
        .mst_nxt    (cfg_d.mst),
        .nxt        (req_d),
        .bad        (bad_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            req_q <= '0;
            bad_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            req_q <= req_d;
            bad_q <= bad_d;
        end
    end

    assign cur_word = pack_word(cfg_q, req_q);

    generate
        if (DATA_W > WORD_W) begin : g_wide
            assign rd_data = {{(DATA_W-WORD_W){1'b0}}, cur_word};
        end else begin : g_fit
            assign rd_data = cur_word[DATA_W-1:0];
        end
    endgenerate

    assign en_o        = cfg_q.en;
    assign master_o    = cfg_q.mst;
    assign rx_mode_o   = cfg_q.mode;
    assign stretch8_o  = cfg_q.stretch;
    assign nack_o      = cfg_q.ack;
    assign start_req_o = req_q.start;
    assign stop_req_o  = req_q.stop;
    assign bad_req_o   = bad_q;

    // R2
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_o || !master_o) |-> (!start_req_o && !stop_req_o));

    // R4
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_req_o && stop_req_o));

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_done || timeout) |=> !start_req_o);

    // R5
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop_done |=> !stop_req_o);

    // R7
    abort_nack_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[B_ABT] |=> nack_o);

    // R9
    master_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_match || arb_lost || gen_call) |=> !master_o);

    // R6
    busy_master_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !addr_match && !arb_lost && !gen_call) |=> (master_o == $past(master_o)));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3] == 1'b0) && (rd_data[DATA_W-1:B_ABT+1] == '0));

endmodule

// File: tb/tb_i2c_ctrl_reg.sv
`timescale 1ns/1ps
module tb_i2c_ctrl_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic busy = 0, start_done = 0, stop_done = 0, timeout = 0, abort_done = 0;
    logic rw_valid = 0, rw_bit = 0, addr_match = 0, arb_lost = 0, gen_call = 0;
    logic en_o, master_o, rx_mode_o, stretch8_o, nack_o, start_req_o, stop_req_o, bad_req_o;

    int checks = 0;
    int errors = 0;
    string req_tag = "R1";

    // reference model state
    bit m_en, m_mst, m_mode, m_str, m_ack, m_sta, m_sto, m_abt, m_bad;

    always #2.5 clk = ~clk;

    i2c_ctrl_reg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .start_done(start_done), .stop_done(stop_done), .timeout(timeout),
        .abort_done(abort_done), .rw_valid(rw_valid), .rw_bit(rw_bit),
        .addr_match(addr_match), .arb_lost(arb_lost), .gen_call(gen_call),
        .en_o(en_o), .master_o(master_o), .rx_mode_o(rx_mode_o), .stretch8_o(stretch8_o),
        .nack_o(nack_o), .start_req_o(start_req_o), .stop_req_o(stop_req_o),
        .bad_req_o(bad_req_o)
    );

    always @(posedge clk) begin
        bit n_en, n_mst, n_mode, n_str, n_ack, n_sta, n_sto, n_abt, n_bad;
        if (rst) begin
            {m_en, m_mst, m_mode, m_str, m_ack, m_sta, m_sto, m_abt, m_bad} = '0;
        end else begin
            n_en = m_en;
            if (wr_en && (!busy || m_abt)) n_en = wr_data[0];
            n_mst = m_mst;
            if (wr_en && !busy) n_mst = wr_data[1];
            if (addr_match || arb_lost || gen_call) n_mst = 0;
            n_mode = m_mode;
            if (!m_mst) begin
                if (rw_valid) n_mode = rw_bit;
            end else if (wr_en && !busy) n_mode = wr_data[2];
            n_str = wr_en ? wr_data[4] : m_str;
            n_ack = m_abt ? 1'b1 : (wr_en ? wr_data[5] : m_ack);
            n_abt = wr_en ? wr_data[8] : m_abt;
            if (abort_done || !n_en) n_abt = 0;
            n_sta = m_sta; n_sto = m_sto; n_bad = 0;
            if (wr_en) begin
                if (wr_data[6] && wr_data[7]) begin
                    n_sta = 0; n_sto = 0; n_bad = 1;
                end else if ((wr_data[6] && m_sto) || (wr_data[7] && m_sta)) begin
                    n_bad = 1;
                end else begin
                    n_sta = wr_data[6]; n_sto = wr_data[7];
                end
            end
            if (start_done || timeout) n_sta = 0;
            if (stop_done) n_sto = 0;
            if (!n_en || !n_mst) begin n_sta = 0; n_sto = 0; end
            m_en = n_en; m_mst = n_mst; m_mode = n_mode; m_str = n_str; m_ack = n_ack;
            m_sta = n_sta; m_sto = n_sto; m_abt = n_abt; m_bad = n_bad;
        end
    end

    function automatic logic [15:0] model_word();
        logic [15:0] w = '0;
        w[0] = m_en; w[1] = m_mst; w[2] = m_mode; w[4] = m_str; w[5] = m_ack;
        w[6] = m_sta; w[7] = m_sto; w[8] = m_abt;
        return w;
    endfunction

    task automatic compare();
        logic [15:0] exp_w = model_word();
        logic [7:0] got_o = {bad_req_o, stop_req_o, start_req_o, nack_o, stretch8_o, rx_mode_o, master_o, en_o};
        logic [7:0] exp_o = {m_bad, m_sto, m_sta, m_ack, m_str, m_mode, m_mst, m_en};
        checks++;
        if (rd_data !== exp_w || got_o !== exp_o) begin
            errors++;
            $display("FAIL %s: rd_data=%h outs=%b expected rd_data=%h outs=%b",
                     req_tag, rd_data, got_o, exp_w, exp_o);
        end
    endtask

    // ev bits: 0 busy,1 start_done,2 stop_done,3 timeout,4 abort_done,
    //          5 rw_valid,6 rw_bit,7 addr_match,8 arb_lost,9 gen_call
    task automatic cyc(input logic w, input logic [15:0] d, input logic [9:0] ev);
        wr_en = w; wr_data = d;
        {gen_call, arb_lost, addr_match, rw_bit, rw_valid, abort_done,
         timeout, stop_done, start_done, busy} = ev;
        @(negedge clk);
        compare();
        wr_en = 0; wr_data = '0;
        {gen_call, arb_lost, addr_match, rw_bit, rw_valid, abort_done,
         timeout, stop_done, start_done, busy} = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 16'h0, 10'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        req_tag = "R1";
        checks++;
        if (rd_data !== 16'h0 || bad_req_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_data=%h bad=%b expected 0000 0", rd_data, bad_req_o);
        end
        idle(2);

        // R11: stretch select
        req_tag = "R11";
        cyc(1, 16'h0010, 10'h0);
        cyc(1, 16'h0000, 10'h001);
        cyc(1, 16'h0010, 10'h001);

        // R2: requests held off until enabled and master
        req_tag = "R2";
        cyc(1, 16'h0041, 10'h0);
        cyc(1, 16'h0082, 10'h0);
        cyc(1, 16'h0043, 10'h0);
        cyc(1, 16'h0001, 10'h0);

        // R5: completion clears, over a same-cycle write
        req_tag = "R5";
        cyc(1, 16'h0043, 10'h0);
        cyc(0, 16'h0, 10'h002);
        cyc(1, 16'h0043, 10'h0);
        cyc(0, 16'h0, 10'h008);
        cyc(1, 16'h0083, 10'h0);
        cyc(1, 16'h0083, 10'h004);
        cyc(1, 16'h0043, 10'h002);

        // R3: both requested at once
        req_tag = "R3";
        cyc(1, 16'h00C3, 10'h0);
        cyc(0, 16'h0, 10'h0);

        // R4: cross request while the other is pending
        req_tag = "R4";
        cyc(1, 16'h0083, 10'h0);
        cyc(1, 16'h0043, 10'h0);
        cyc(0, 16'h0, 10'h004);
        cyc(1, 16'h0043, 10'h0);
        cyc(1, 16'h0083, 10'h0);
        cyc(0, 16'h0, 10'h002);

        // R6: busy locks enable, master, direction
        req_tag = "R6";
        cyc(1, 16'h0007, 10'h0);
        cyc(1, 16'h0000, 10'h001);
        cyc(1, 16'h0003, 10'h001);
        cyc(1, 16'h0101, 10'h001);
        cyc(1, 16'h0100, 10'h001);
        cyc(1, 16'h0007, 10'h0);

        // R7: abort forces NACK, clears on completion or disable
        req_tag = "R7";
        cyc(1, 16'h0103, 10'h0);
        cyc(1, 16'h0103, 10'h0);
        cyc(1, 16'h0103, 10'h0);
        cyc(1, 16'h0103, 10'h010);
        cyc(1, 16'h0003, 10'h0);
        cyc(1, 16'h0023, 10'h0);
        cyc(1, 16'h0100, 10'h0);

        // R8: slave direction from received R/W bit
        req_tag = "R8";
        cyc(1, 16'h0001, 10'h0);
        cyc(1, 16'h0005, 10'h0);
        cyc(0, 16'h0, 10'h060);
        cyc(1, 16'h0001, 10'h0);
        cyc(1, 16'h0001, 10'h020);
        cyc(1, 16'h0005, 10'h020);

        // R9: master dropped by hardware events
        req_tag = "R9";
        cyc(1, 16'h0043, 10'h0);
        cyc(1, 16'h0043, 10'h080);
        cyc(1, 16'h0003, 10'h0);
        cyc(1, 16'h0003, 10'h100);
        cyc(1, 16'h0003, 10'h0);
        cyc(0, 16'h0, 10'h200);

        // R10: reserved bits ignore writes
        req_tag = "R10";
        cyc(1, 16'hFE08, 10'h0);
        cyc(1, 16'hFF3F, 10'h0);
        cyc(1, 16'hFE3B, 10'h0);
        idle(2);

        // R1: reset mid-run
        req_tag = "R1";
        cyc(1, 16'h0133, 10'h0);
        rst = 1;
        cyc(0, 16'h0, 10'h0);
        rst = 0;
        cyc(0, 16'h0, 10'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule